// File: doc/BRIEF.md
# Lane-Partitioned Vector Integer Subtractor

This block subtracts one vector operand from another, lane by lane, with the lane width picked for each operation. One shared subtract path covers the whole vector. It is split into byte-sized slices, and the borrow between slices is passed on only inside a lane. At every lane boundary the chain is cut and the slice there gets a fresh +1, because each difference is formed as the first operand plus the inverted second operand plus one. Lanes therefore never affect each other, and each lane wraps modulo two to the power of its width. There is no saturation and no flag output.

A caller presents both operands, a 2-bit element-size code and a mode bit with a valid strobe. The differences appear one clock later in an output register, together with an output valid strobe. In full mode the whole vector is used. In half mode only the low half is computed and the upper half of the result is forced to zero.

Top module: `lane_sub_vec`

## Requirements
- R1: Each result lane equals the matching lane of `op_a` minus the matching lane of `op_b`, modulo 2^width.
- R2: `elem_size` selects the lane width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64.
- R3: No borrow crosses a lane boundary. A lane's result depends only on that lane of the two operands.
- R4: Underflow wraps. 0 minus 1 gives all ones in the lane. The most negative value minus the most positive value (for example 8'h80 - 8'h7F) gives 1.
- R5: With `quad_mode` = 1 all 128 bits are processed. With `quad_mode` = 0 only bits [63:0] are processed and `result[127:64]` is zero.
- R6: `out_valid` is high in the cycle after the clock edge that samples `in_valid` high. At that point `result` holds the differences of that input, including when valid inputs come back to back.
- R7: After a clock edge that samples `in_valid` low, `out_valid` is low and `result` keeps its previous value.
- R8: A synchronous active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 128 | Minuend vector |
| op_b | input | 128 | Subtrahend vector |
| elem_size | input | 2 | Lane width code (00=8, 01=16, 10=32, 11=64) |
| quad_mode | input | 1 | 1 = full 128-bit vector, 0 = low 64 bits only |
| out_valid | output | 1 | Registered result is valid |
| result | output | 128 | Registered lane-wise differences |

## Verification
The bench builds the block with its default parameters: a 128-bit vector and 8-bit slices. That gives sixteen slices, so all four lane widths are available in both the full and the half mode, and the 64-bit lanes cover eight slices joined by the internal borrow chain. The corner cases target the boundaries that are cut. A lone borrow placed in lane zero has to stay there, and all-ones and minimum-minus-maximum patterns are applied at each width. An independent per-lane model checks scattered operands against the result.

// File: rtl/lane_sub_pkg.sv
package lane_sub_pkg;
   typedef enum logic [1:0] {
      ESZ_8  = 2'b00,
      ESZ_16 = 2'b01,
      ESZ_32 = 2'b10,
      ESZ_64 = 2'b11
   } elem_size_e;

   // number of slices spanned by one lane for a given size code
   function automatic int unsigned slices_per_lane(input elem_size_e esz);
      return 32'd1 << esz;
   endfunction
endpackage

// File: rtl/lane_sub_bounds.sv
// Marks the slices that begin a new lane for the selected element size.
module lane_sub_bounds
   import lane_sub_pkg::*;
#(
   parameter int NUM_SLICES = 16
) (
   input  elem_size_e              esz,
   output logic [NUM_SLICES-1:1]   lane_head
);
   localparam int IDX_W = $clog2(NUM_SLICES);

   if (NUM_SLICES < 8) begin : g_chk_slices
      $error("lane_sub_bounds: need at least 8 slices");
   end

   logic [IDX_W-1:0] span_mask;

   always_comb begin
      span_mask = IDX_W'(slices_per_lane(esz) - 1);
      for (int k = 1; k < NUM_SLICES; k++) begin
         lane_head[k] = ((IDX_W'(k) & span_mask) == '0);
      end
   end
endmodule

// File: rtl/lane_sub_slices.sv
// Sliced subtract path: a + ~b + 1, with the carry restarted at lane heads.
module lane_sub_slices #(
   parameter int SLICE_W    = 8,
   parameter int NUM_SLICES = 16,
   localparam int VEC_W     = SLICE_W * NUM_SLICES
) (
   input  logic [VEC_W-1:0]      minuend,
   input  logic [VEC_W-1:0]      subtrahend,
   input  logic [NUM_SLICES-1:1] lane_head,
   output logic [VEC_W-1:0]      diff
);
   logic [NUM_SLICES-2:0] carry;

   for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
      logic               cin;
      logic [SLICE_W-1:0] a_s;
      logic [SLICE_W-1:0] nb_s;

      assign a_s  = minuend[k*SLICE_W +: SLICE_W];
      assign nb_s = ~subtrahend[k*SLICE_W +: SLICE_W];

      if (k == 0) begin : g_first
         assign cin = 1'b1;
      end else begin : g_inner
         assign cin = lane_head[k] ? 1'b1 : carry[k-1];
      end

      if (k == NUM_SLICES - 1) begin : g_last
         assign diff[k*SLICE_W +: SLICE_W] = a_s + nb_s + SLICE_W'(cin);
      end else begin : g_chain
         logic [SLICE_W:0] sum;
         assign sum = {1'b0, a_s} + {1'b0, nb_s} + {{SLICE_W{1'b0}}, cin};
         assign diff[k*SLICE_W +: SLICE_W] = sum[SLICE_W-1:0];
         assign carry[k] = sum[SLICE_W];
      end
   end
endmodule

// File: rtl/lane_sub_vec.sv
module lane_sub_vec
   import lane_sub_pkg::*;
#(
   parameter int VEC_W   = 128,
   parameter int SLICE_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] op_a,
   input  logic [VEC_W-1:0] op_b,
   input  logic [1:0]       elem_size,
   input  logic             quad_mode,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   localparam int NUM_SLICES = VEC_W / SLICE_W;
   localparam int HALF_W     = VEC_W / 2;
   localparam int MAX_LANE_W = SLICE_W * 8;

   if (SLICE_W < 1 || (VEC_W % (2 * MAX_LANE_W)) != 0) begin : g_chk_geom
      $error("lane_sub_vec: VEC_W must be a multiple of 16*SLICE_W");
   end

   elem_size_e              esz;
   logic [NUM_SLICES-1:1]   lane_head;
   logic [VEC_W-1:0]        diff_raw;
   logic [VEC_W-1:0]        diff_mode;

   assign esz = elem_size_e'(elem_size);

   lane_sub_bounds #(.NUM_SLICES(NUM_SLICES)) bounds_i (
      .esz       (esz),
      .lane_head (lane_head)
   );

   lane_sub_slices #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) slices_i (
      .minuend    (op_a),
      .subtrahend (op_b),
      .lane_head  (lane_head),
      .diff       (diff_raw)
   );

   // half mode keeps only the low half of the vector
   assign diff_mode = quad_mode ? diff_raw : {{HALF_W{1'b0}}, diff_raw[HALF_W-1:0]};

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= diff_mode;
      end
   end

   // R6: a sampled valid produces a valid result next cycle
   p_valid_next_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R7: idle cycles give no valid and a held result
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(result)));

   // R5: half mode leaves the upper half at zero
   p_half_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !quad_mode) |=> (result[VEC_W-1:HALF_W] == '0));

   // R1/R3: lowest 8-bit lane is an isolated wrapping difference
   p_low_byte_lane_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && elem_size == 2'b00) |=>
      (result[SLICE_W-1:0] == SLICE_W'($past(op_a[SLICE_W-1:0]) - $past(op_b[SLICE_W-1:0]))));

   // R2: topmost widest lane in full mode spans the full lane width
   p_top_wide_lane_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && quad_mode && elem_size == 2'b11) |=>
      (result[VEC_W-1 -: MAX_LANE_W] ==
       MAX_LANE_W'($past(op_a[VEC_W-1 -: MAX_LANE_W]) - $past(op_b[VEC_W-1 -: MAX_LANE_W]))));

   // R8: reset clears the output register
   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0));
endmodule

// File: tb/lane_sub_vec_tb_top.sv
module lane_sub_vec_tb_top;
   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic [127:0] op_a, op_b;
   logic [1:0]   elem_size;
   logic         quad_mode;
   logic         out_valid;
   logic [127:0] result;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   lane_sub_vec dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .elem_size(elem_size), .quad_mode(quad_mode),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic [127:0] ref_sub(input logic [127:0] a, input logic [127:0] b,
                                            input logic [1:0] sz, input logic q);
      int w = 8 << sz;
      int lanes = (q ? 128 : 64) / w;
      logic [63:0] msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      logic [127:0] r = '0;
      for (int i = 0; i < lanes; i++) begin
         logic [63:0] la = 64'(a >> (i * w)) & msk;
         logic [63:0] lb = 64'(b >> (i * w)) & msk;
         logic [63:0] d  = (la - lb) & msk;
         r |= 128'(d) << (i * w);
      end
      return r;
   endfunction

   function automatic logic [127:0] fill_lanes(input logic [63:0] v, input logic [1:0] sz);
      int w = 8 << sz;
      logic [127:0] r = '0;
      for (int i = 0; i < 128 / w; i++) r |= 128'(v) << (i * w);
      return r;
   endfunction

   task automatic chk_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_bit(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %b expected %b", tag, act, exp);
      end
   endtask

   // one valid operation, then sample after the capturing edge
   task automatic issue(input logic [127:0] a, input logic [127:0] b,
                        input logic [1:0] sz, input logic q, input logic [127:0] exp, input string tag);
      @(negedge clk);
      in_valid = 1'b1; op_a = a; op_b = b; elem_size = sz; quad_mode = q;
      @(negedge clk);
      in_valid = 1'b0; op_a = ~a; op_b = '0;
      chk_bit({tag, " R6 valid"}, out_valid, 1'b1);
      chk_vec(tag, result, exp);
   endtask

   task automatic t_reset;
      rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; elem_size = 2'b00; quad_mode = 1'b1;
      repeat (3) @(negedge clk);
      chk_bit("R8 reset valid", out_valid, 1'b0);
      chk_vec("R8 reset result", result, '0);
      rst = 1'b0;
   endtask

   task automatic t_sizes;
      for (int sz = 0; sz < 4; sz++) begin
         for (int n = 0; n < 4; n++) begin
            logic [127:0] a = {$urandom(), $urandom(), $urandom(), $urandom()};
            logic [127:0] b = {$urandom(), $urandom(), $urandom(), $urandom()};
            issue(a, b, 2'(sz), 1'b1, ref_sub(a, b, 2'(sz), 1'b1), "R1 R2 random full");
         end
      end
   endtask

   task automatic t_corners;
      for (int sz = 0; sz < 4; sz++) begin
         int w = 8 << sz;
         logic [63:0] minv = 64'd1 << (w - 1);
         logic [63:0] maxv = minv - 64'd1;
         issue('0, fill_lanes(64'd1, 2'(sz)), 2'(sz), 1'b1, '1, "R4 zero minus one");
         issue(fill_lanes(minv, 2'(sz)), fill_lanes(maxv, 2'(sz)), 2'(sz), 1'b1,
               fill_lanes(64'd1, 2'(sz)), "R4 min minus max");
      end
   endtask

   task automatic t_isolation;
      for (int sz = 0; sz < 4; sz++) begin
         int w = 8 << sz;
         logic [127:0] lane0 = (w == 64) ? 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF
                                         : ((128'd1 << w) - 128'd1);
         issue('0, 128'd1, 2'(sz), 1'b1, lane0, "R3 borrow stays in lane 0");
      end
      // alternating lanes: only odd bytes borrow
      issue(128'h00FF_00FF_00FF_00FF_00FF_00FF_00FF_00FF,
            128'h0100_0100_0100_0100_0100_0100_0100_0100, 2'b00, 1'b1,
            128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, "R3 byte lanes");
      issue(128'h00FF_00FF_00FF_00FF_00FF_00FF_00FF_00FF,
            128'h0100_0100_0100_0100_0100_0100_0100_0100, 2'b01, 1'b1,
            128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, "R3 half lanes");
   endtask

   task automatic t_double;
      for (int sz = 0; sz < 4; sz++) begin
         logic [127:0] a = {$urandom(), $urandom(), $urandom(), $urandom()} | {4{32'h0100_0000}};
         logic [127:0] b = {$urandom(), $urandom(), $urandom(), $urandom()};
         issue(a, b, 2'(sz), 1'b0, ref_sub(a, b, 2'(sz), 1'b0), "R5 half mode");
         chk_vec("R5 upper zero", {result[127:64], 64'd0}, '0);
      end
   endtask

   task automatic t_hold_and_burst;
      logic [127:0] a1 = 128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321;
      logic [127:0] b1 = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
      logic [127:0] a2 = 128'h8000_0000_0000_0000_0000_0000_0000_0000;
      logic [127:0] b2 = 128'h0000_0000_0000_0001_0000_0000_0000_0001;
      logic [127:0] e1 = ref_sub(a1, b1, 2'b10, 1'b1);
      issue(a1, b1, 2'b10, 1'b1, e1, "R1 32-bit");
      @(negedge clk);
      chk_bit("R7 idle valid", out_valid, 1'b0);
      chk_vec("R7 idle hold", result, e1);
      repeat (2) @(negedge clk);
      chk_vec("R7 idle hold later", result, e1);
      // back to back
      @(negedge clk);
      in_valid = 1'b1; op_a = a1; op_b = b1; elem_size = 2'b10; quad_mode = 1'b1;
      @(negedge clk);
      chk_bit("R6 burst first valid", out_valid, 1'b1);
      chk_vec("R6 burst first", result, e1);
      op_a = a2; op_b = b2; elem_size = 2'b11; quad_mode = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk_bit("R6 burst second valid", out_valid, 1'b1);
      chk_vec("R6 burst second", result, 128'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
      // reset mid-stream
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk_bit("R8 rerun reset valid", out_valid, 1'b0);
      chk_vec("R8 rerun reset result", result, '0);
   endtask

   initial begin
      t_reset();
      t_sizes();
      t_corners();
      t_isolation();
      t_double();
      t_hold_and_burst();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule